// File: doc/BRIEF.md
# Command Phase Handshake Sequencer

This block runs the byte-by-byte command intake of a disk controller front end. A host writes a command code followed by its parameter bytes through a single byte-write port. Before each write it polls a status byte that carries a ready-for-transfer flag (RQM) and a direction flag (DIO). The sequencer accepts a byte only while RQM is set and DIO is clear. After each accepted byte it drops RQM for a fixed processing time. It then either raises RQM again to ask for the next parameter, or hands the assembled command to the execution phase.

The first byte is decoded to find how many parameter bytes must follow. When the opcode is not recognised, no parameters are requested and execution is skipped. Instead the sequencer turns the bus around by setting DIO and RQM, and presents a single invalid-command result byte until the host reads it. A core reset input discards any partially received command and returns the block to the idle command phase.

Top module: `cmd_phase_seq`

## Requirements
- R1: After the asynchronous reset is released, status_o reads 0x80 (RQM=1, DIO=0, busy=0), and neither exec_start_o nor res_start_o is asserted.
- R2: A write (wr_en_i high at a clock edge) is accepted only while RQM=1 and DIO=0. A write at any other time has no effect on the status, the captured bytes or the phase.
- R3: After an accepted write, RQM reads 0 for exactly PROC_CYC (default 2) cycles before the next decision takes effect.
- R4: The parameter count comes from bits [4:0] of the command byte: 0x08 takes 0 bytes, 0x04 and 0x07 take 1, 0x03 and 0x0F take 2, and 0x05 and 0x06 take 8. Bits [7:5] do not affect the count.
- R5: Bytes are taken in order. exec_opcode_o holds the full command byte, and parameter k appears at exec_params_o[8k+7:8k]. Slots the command does not use read zero.
- R6: Once the last byte of a valid command has been processed, exec_start_o pulses for one cycle. RQM then stays 0 and busy stays 1 until exec_done_i, which returns the block to idle.
- R7: For an unrecognised opcode, res_start_o pulses for one cycle after processing. The status then reads RQM=1, DIO=1 and busy=1, and result_data_o is 0x80. A pulse on rd_result_i returns the block to idle.
- R8: A high core_rst_i at a clock edge returns the block to idle (status 0x80) in the next cycle and discards any partly received command. It takes precedence over a write in the same cycle.
- R9: In status_o, bit 7 is RQM, bit 6 is DIO and bit 4 is busy, which is set whenever the block is not idle. Bits 5 and 3:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_rst_i | input | 1 | Synchronous core reset back to the idle command phase |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_data_i | input | DATA_W | Host write byte |
| status_o | output | 8 | Main status: RQM, DIO, busy |
| exec_start_o | output | 1 | One-cycle handoff to the execution phase |
| exec_opcode_o | output | DATA_W | Captured command byte |
| exec_params_o | output | MAX_PARAMS*DATA_W | Captured parameter bytes, slot k at bits [8k+7:8k] |
| exec_done_i | input | 1 | Execution phase finished |
| res_start_o | output | 1 | One-cycle handoff to the result phase for an illegal command |
| result_data_o | output | DATA_W | Invalid-command result byte while in the result phase, else 0 |
| rd_result_i | input | 1 | Host read strobe for the result byte |

## Verification
Commands are sent with every parameter count in the table: zero, one, two and eight bytes. These patterns separate a wrong count entry from a wrong decision point, and the eight-byte case also exposes slot-ordering errors. The same opcodes are repeated with the upper three bits set, which shows whether those bits leak into the decode. Stray writes are issued while RQM is low, during execution and during the result phase; any of them being taken shows up as shifted parameters or an early phase change. Illegal opcodes, a core reset in the middle of a command, and a core reset that coincides with a write cover the escape paths.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PROC,
    PH_PARAM,
    PH_EXEC,
    PH_RESULT
  } phase_e;

  localparam int OPC_W   = 5;
  localparam int ST_RQM  = 7;
  localparam int ST_DIO  = 6;
  localparam int ST_BUSY = 4;
  localparam logic [7:0] INVALID_RESULT = 8'h80;
endpackage

// File: rtl/cps_decode.sv
module cps_decode import cps_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic [OPC_W-1:0] opc_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o
);
  always_comb begin
    valid_o = 1'b1;
    count_o = '0;
    unique case (opc_i)
      5'h08:        count_o = CNT_W'(0);
      5'h04, 5'h07: count_o = CNT_W'(1);
      5'h03, 5'h0F: count_o = CNT_W'(2);
      5'h05, 5'h06: count_o = CNT_W'(8);
      default:      valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cps_param_store.sv
module cps_param_store #(
  parameter int DATA_W     = 8,
  parameter int MAX_PARAMS = 8,
  localparam int IDX_W     = (MAX_PARAMS > 1) ? $clog2(MAX_PARAMS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         wr_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [MAX_PARAMS*DATA_W-1:0] params_o
);
  for (genvar g = 0; g < MAX_PARAMS; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            slot_q <= '0;
      else if (clr_i)                         slot_q <= '0;
      else if (wr_i && idx_i == IDX_W'(g))    slot_q <= data_i;
    end
    assign params_o[g*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/cps_proc_timer.sv
module cps_proc_timer #(
  parameter int PROC_CYC = 2,
  localparam int TW      = (PROC_CYC > 1) ? $clog2(PROC_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= TW'(PROC_CYC - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/cmd_phase_seq.sv
module cmd_phase_seq import cps_pkg::*; #(
  parameter int DATA_W     = 8,
  parameter int MAX_PARAMS = 8,
  parameter int PROC_CYC   = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         core_rst_i,
  input  logic                         wr_en_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic [7:0]                   status_o,
  output logic                         exec_start_o,
  output logic [DATA_W-1:0]            exec_opcode_o,
  output logic [MAX_PARAMS*DATA_W-1:0] exec_params_o,
  input  logic                         exec_done_i,
  output logic                         res_start_o,
  output logic [DATA_W-1:0]            result_data_o,
  input  logic                         rd_result_i
);
  localparam int CNT_W = $clog2(MAX_PARAMS + 1);
  localparam int IDX_W = (MAX_PARAMS > 1) ? $clog2(MAX_PARAMS) : 1;

  phase_e            ph_q;
  logic [DATA_W-1:0] op_q;
  logic [CNT_W-1:0]  need_q, got_q;
  logic              valid_q, exec_start_q, res_start_q;
  logic              dec_valid, tmr_done, accept, rqm, dio;
  logic [CNT_W-1:0]  dec_count;

  assign rqm    = (ph_q == PH_IDLE) || (ph_q == PH_PARAM) || (ph_q == PH_RESULT);
  assign dio    = (ph_q == PH_RESULT);
  assign accept = wr_en_i && !core_rst_i && (ph_q == PH_IDLE || ph_q == PH_PARAM);

  cps_decode #(.CNT_W(CNT_W)) u_decode (
    .opc_i   (wr_data_i[OPC_W-1:0]),
    .valid_o (dec_valid),
    .count_o (dec_count)
  );

  cps_proc_timer #(.PROC_CYC(PROC_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .done_o (tmr_done)
  );

  cps_param_store #(.DATA_W(DATA_W), .MAX_PARAMS(MAX_PARAMS)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (core_rst_i || (accept && ph_q == PH_IDLE)),
    .wr_i     (accept && ph_q == PH_PARAM),
    .idx_i    (got_q[IDX_W-1:0]),
    .data_i   (wr_data_i),
    .params_o (exec_params_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q         <= PH_IDLE;
      op_q         <= '0;
      need_q       <= '0;
      got_q        <= '0;
      valid_q      <= 1'b0;
      exec_start_q <= 1'b0;
      res_start_q  <= 1'b0;
    end else begin
      exec_start_q <= 1'b0;
      res_start_q  <= 1'b0;
      if (core_rst_i) begin
        ph_q  <= PH_IDLE;
        got_q <= '0;
      end else begin
        unique case (ph_q)
          PH_IDLE: if (wr_en_i) begin
            op_q    <= wr_data_i;
            need_q  <= dec_count;
            valid_q <= dec_valid;
            got_q   <= '0;
            ph_q    <= PH_PROC;
          end
          PH_PROC: if (tmr_done) begin
            if (!valid_q) begin
              ph_q        <= PH_RESULT;
              res_start_q <= 1'b1;
            end else if (got_q == need_q) begin
              ph_q         <= PH_EXEC;
              exec_start_q <= 1'b1;
            end else begin
              ph_q <= PH_PARAM;
            end
          end
          PH_PARAM: if (wr_en_i) begin
            got_q <= got_q + 1'b1;
            ph_q  <= PH_PROC;
          end
          PH_EXEC:   if (exec_done_i) ph_q <= PH_IDLE;
          PH_RESULT: if (rd_result_i) ph_q <= PH_IDLE;
          default:   ph_q <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_RQM]  = rqm;
    status_o[ST_DIO]  = dio;
    status_o[ST_BUSY] = (ph_q != PH_IDLE);
  end

  assign exec_start_o  = exec_start_q;
  assign res_start_o   = res_start_q;
  assign exec_opcode_o = op_q;
  assign result_data_o = dio ? DATA_W'(INVALID_RESULT) : '0;
endmodule

// File: rtl/cmd_phase_seq_chk.sv
module cmd_phase_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              core_rst_i,
  input logic              wr_en_i,
  input logic [7:0]        status_o,
  input logic              exec_start_o,
  input logic              res_start_o,
  input logic [DATA_W-1:0] result_data_o
);
  AST_CORE_RST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_i |=> status_o == 8'h80); // R8

  AST_WRITE_DROPS_RQM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !core_rst_i && status_o[7] && !status_o[6]) |=> !status_o[7]); // R3

  AST_EXEC_HOLDS_RQM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |-> (!status_o[7] && !status_o[6] && status_o[4])); // R6

  AST_EXEC_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |=> !exec_start_o); // R6

  AST_RESULT_TURNAROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6] |-> (status_o[7] && status_o[4] && result_data_o == DATA_W'(8'h80))); // R7

  AST_RES_START_DIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_start_o |-> status_o[6]); // R7

  AST_STATUS_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[5] == 1'b0 && status_o[3:0] == 4'h0)); // R9

  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[4] |-> (status_o[7] && !status_o[6] && !exec_start_o && !res_start_o)); // R1
endmodule

bind cmd_phase_seq cmd_phase_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .core_rst_i    (core_rst_i),
  .wr_en_i       (wr_en_i),
  .status_o      (status_o),
  .exec_start_o  (exec_start_o),
  .res_start_o   (res_start_o),
  .result_data_o (result_data_o)
);

// File: tb/cmd_phase_seq_test.sv
module cmd_phase_seq_test;
  localparam int CLK_P = 10;
  localparam int NPAR  = 8;
  localparam int PROC  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic core_rst = 1'b0, wr_en = 1'b0, exec_done = 1'b0, rd_res = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] status, exec_op, result_data;
  logic [NPAR*8-1:0] exec_par;
  logic exec_start, res_start;

  int n_chk = 0, n_fail = 0;
  bit live = 1'b0, finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cmd_phase_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .core_rst_i(core_rst),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .status_o(status),
    .exec_start_o(exec_start), .exec_opcode_o(exec_op), .exec_params_o(exec_par),
    .exec_done_i(exec_done), .res_start_o(res_start),
    .result_data_o(result_data), .rd_result_i(rd_res)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // parameter count per R4, -1 means illegal
  function automatic int op_count(input logic [7:0] b);
    case (b[4:0])
      5'h08:        return 0;
      5'h04, 5'h07: return 1;
      5'h03, 5'h0F: return 2;
      5'h05, 5'h06: return 8;
      default:      return -1;
    endcase
  endfunction

  // behavioural reference: 0 idle, 1 processing, 2 awaiting param, 3 executing, 4 result
  int m_ph, m_t, m_need;
  logic [7:0] m_op;
  logic [7:0] m_par[$];
  bit m_exec, m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_need = 0; m_op = '0; m_par.delete(); m_exec = 0; m_res = 0;
    end else begin
      m_exec = 0; m_res = 0;
      if (core_rst) begin
        m_ph = 0; m_par.delete();
      end else begin
        case (m_ph)
          0: if (wr_en) begin
            m_op = wr_data; m_need = op_count(wr_data); m_par.delete(); m_ph = 1; m_t = PROC;
          end
          1: begin
            m_t--;
            if (m_t == 0) begin
              if (m_need < 0) begin m_ph = 4; m_res = 1; end
              else if (m_par.size() == m_need) begin m_ph = 3; m_exec = 1; end
              else m_ph = 2;
            end
          end
          2: if (wr_en) begin m_par.push_back(wr_data); m_ph = 1; m_t = PROC; end
          3: if (exec_done) m_ph = 0;
          4: if (rd_res) m_ph = 0;
          default: m_ph = 0;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && live) begin
      logic [7:0] exp_st;
      exp_st = {(m_ph == 0 || m_ph == 2 || m_ph == 4), (m_ph == 4), 1'b0, (m_ph != 0), 4'h0};
      chk(status == exp_st, "R3", "status (R2 R9)", 64'(status), 64'(exp_st));
      chk(exec_start == m_exec, "R6", "exec_start", 64'(exec_start), 64'(m_exec));
      chk(res_start == m_res, "R7", "res_start", 64'(res_start), 64'(m_res));
      chk(result_data == ((m_ph == 4) ? 8'h80 : 8'h00), "R7", "result_data",
          64'(result_data), 64'((m_ph == 4) ? 8'h80 : 8'h00));
      if (m_exec) begin
        chk(exec_op == m_op, "R5", "exec_opcode", 64'(exec_op), 64'(m_op));
        for (int i = 0; i < NPAR; i++) begin
          logic [7:0] e;
          e = (i < m_par.size()) ? m_par[i] : 8'h00;
          chk(exec_par[i*8 +: 8] == e, "R5", $sformatf("param slot %0d (R4)", i),
              64'(exec_par[i*8 +: 8]), 64'(e));
        end
      end
    end
  end

  task automatic tick;
    @(posedge clk);
    #(CLK_P/4);
  endtask

  // R2: waits for RQM=1 DIO=0, optionally pokes a stray write while RQM is low
  task automatic put(input logic [7:0] b, input bit poke);
    while (!(status[7] && !status[6])) tick();
    wr_en = 1'b1; wr_data = b;
    tick();
    if (poke) begin wr_data = 8'hA5; tick(); end
    wr_en = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] op, input int n, input logic [7:0] seed, input bit poke);
    put(op, poke);
    for (int i = 0; i < n; i++) put(seed + 8'(i * 17), poke);
    for (int k = 0; k < 20 && !(exec_start || res_start); k++) tick();
    if (exec_start) begin
      tick();
      wr_en = 1'b1; wr_data = 8'h5A; tick(); wr_en = 1'b0; // R2 stray write during execution
      exec_done = 1'b1; tick(); exec_done = 1'b0;
    end else if (res_start) begin
      wr_en = 1'b1; wr_data = 8'h08; tick(); wr_en = 1'b0; // R2 stray write with DIO=1
      rd_res = 1'b1; tick(); rd_res = 1'b0;
    end
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_P/4) rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(status == 8'h80, "R1", "status after reset", 64'(status), 64'h80);
    chk(!exec_start && !res_start, "R1", "strobes after reset", 64'({exec_start, res_start}), 64'h0);
    live = 1'b1;

    // R4 counts 0, 2, 8, 1, 1, 2
    run_cmd(8'h08, 0, 8'h00, 1'b0);
    run_cmd(8'h03, 2, 8'h31, 1'b0);
    run_cmd(8'h06, 8, 8'h11, 1'b1);
    run_cmd(8'h07, 1, 8'h42, 1'b1);
    run_cmd(8'h04, 1, 8'h77, 1'b0);
    run_cmd(8'h0F, 2, 8'h90, 1'b1);
    // R4 upper bits ignored
    run_cmd(8'hE5, 8, 8'h23, 1'b0);
    run_cmd(8'h48, 0, 8'h00, 1'b1);
    // R7 illegal opcodes
    run_cmd(8'h1F, 0, 8'h00, 1'b0);
    run_cmd(8'h00, 0, 8'h00, 1'b1);

    // R8 core reset mid-command
    put(8'h06, 1'b0);
    for (int i = 0; i < 3; i++) put(8'hC0 + 8'(i), 1'b0);
    core_rst = 1'b1; tick(); core_rst = 1'b0;
    chk(status == 8'h80, "R8", "status after core reset", 64'(status), 64'h80);
    run_cmd(8'h03, 2, 8'hD4, 1'b0);

    // R8 core reset wins over a simultaneous write
    wr_en = 1'b1; wr_data = 8'h06; core_rst = 1'b1; tick();
    wr_en = 1'b0; core_rst = 1'b0;
    chk(status == 8'h80, "R8", "write with core reset", 64'(status), 64'h80);
    run_cmd(8'h08, 0, 8'h00, 1'b0);

    repeat (4) tick();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule